// File: doc/BRIEF.md
# Manchester / Bi-phase Line Modulator

This block turns bytes into a self-clocking serial line code. A producer hands over bytes through a valid/ready handshake. The block shifts out the most significant bit first. Each bit is drawn on the line as two half-bit levels, and the timer's `half_tick` pulse paces every half-bit. A select input chooses between Manchester and bi-phase coding.

The byte register always holds a whole byte. A frame can still be any length from 1 to 2^CNT_W bits, because a small down-counter loaded from `bit_count` ends the frame once the programmed number of bits has gone out. Bits left over in the last byte are then discarded. At the end of a frame the line returns to a low idle level and `done` pulses for one clock. The next byte starts a fresh frame.

Top module: `linecode_modulator`

## Requirements
- R1: After reset `line_out` is 0, `done` is 0 and `load_ready` is 1.
- R2: A byte is taken in a cycle where `load_valid` and `load_ready` are both 1. `load_ready` stays 0 while any of its eight bits has not yet started. It returns to 1 in the cycle after the eighth bit starts.
- R3: With `code_sel` = 0 (Manchester), a 1 is driven high for the first half-bit and low for the second. A 0 is driven low, then high.
- R4: With `code_sel` = 1 (bi-phase), the level inverts at the start of every bit relative to the level before it, with the idle level 0 before the first bit. It inverts again at mid-bit only when the bit is 0.
- R5: Bits go out MSB first. Each bit covers two `half_tick` pulses. The first bit begins on the first `half_tick` seen while idle with a byte held. Each output level appears in the cycle after its `half_tick`.
- R6: A frame carries `bit_count`+1 bits, with `bit_count` sampled when the frame starts. The `half_tick` after the last bit's second half drives `line_out` to 0 and raises `done` for exactly one cycle.
- R7: `code_sel` is sampled when a frame starts. Changing it during the frame has no effect on that frame.
- R8: Bits of the last byte that were not sent are discarded when the frame ends, so `load_ready` is 1 after `done`. The next frame starts with the next byte loaded.
- R9: Suppose a bit boundary arrives while bits remain in the frame but no byte is held. The line then keeps its level, and the next bit begins on the first `half_tick` after a byte is loaded.
- R10: A byte accepted in the same cycle as the frame-ending `half_tick` is kept, and it begins the next frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| load_valid | input | 1 | Byte offered |
| load_ready | output | 1 | Byte register empty, byte can be taken |
| load_data | input | DATA_W | Byte to send, MSB first |
| half_tick | input | 1 | One-cycle pulse marking each half-bit boundary |
| code_sel | input | 1 | 0 = Manchester, 1 = bi-phase |
| bit_count | input | CNT_W | Frame length minus one |
| line_out | output | 1 | Encoded line level |
| done | output | 1 | One-cycle pulse at frame end |

## Verification
Two events can fall in the same clock: the frame-ending `half_tick`, which flushes the byte register, and the acceptance of a new byte into that same register. The bench provokes this with an 8-bit frame. The byte register is then empty during the last bit, so `load_valid` can be raised in the exact cycle of the finishing tick. The collision counts as handled correctly under two conditions. First, `load_ready` must read 0 after `done`. Second, the next frame must start on its first tick without a further load and must carry that byte's bits. A stalled boundary, where the byte arrives only after several idle ticks, is checked the same way against the held level.

// File: rtl/lcm_pkg.sv
package lcm_pkg;
  typedef enum logic {
    CODE_MANCH   = 1'b0,
    CODE_BIPHASE = 1'b1
  } code_e;
endpackage

// File: rtl/lcm_shifter.sv
module lcm_shifter #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              shift_i,
  input  logic              flush_i,
  output logic              empty_o,
  output logic              msb_o
);
  localparam int CW = $clog2(DATA_W + 1);

  logic [DATA_W-1:0] data_q, data_n;
  logic [CW-1:0]     cnt_q, cnt_n;
  logic              upd;

  always_comb begin
    data_n = data_q;
    cnt_n  = cnt_q;
    if (load_i) begin
      data_n = data_i;
      cnt_n  = CW'(DATA_W);
    end else if (flush_i) begin
      cnt_n  = '0;
    end else if (shift_i) begin
      data_n = {data_q[DATA_W-2:0], 1'b0};
      cnt_n  = cnt_q - 1'b1;
    end
  end

  assign upd = load_i | flush_i | shift_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      cnt_q  <= '0;
    end else if (upd) begin
      data_q <= data_n;
      cnt_q  <= cnt_n;
    end
  end

  assign empty_o = (cnt_q == '0);
  assign msb_o   = data_q[DATA_W-1];

  assert_shift_has_bit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    shift_i |-> (cnt_q != '0));
  assert_load_only_empty_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (cnt_q == CW'(DATA_W)));
endmodule

// File: rtl/lcm_bitcount.sv
module lcm_bitcount #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [CNT_W-1:0] len_i,
  input  logic             dec_i,
  output logic             last_o
);
  logic [CNT_W-1:0] rem_q, rem_n;
  logic             upd;

  always_comb begin
    rem_n = rem_q;
    if (start_i)    rem_n = len_i;
    else if (dec_i) rem_n = rem_q - 1'b1;
  end

  assign upd = start_i | dec_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   rem_q <= '0;
    else if (upd) rem_q <= rem_n;
  end

  assign last_o = (rem_q == '0);

  assert_no_dec_past_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    dec_i |-> (rem_q != '0));
endmodule

// File: rtl/lcm_encoder.sv
module lcm_encoder
  import lcm_pkg::*;
(
  input  code_e mode_i,
  input  logic  new_bit_i,
  input  logic  cur_bit_i,
  input  logic  prev_lvl_i,
  output logic  first_o,
  output logic  second_o
);
  always_comb begin
    if (mode_i == CODE_MANCH) begin
      first_o  = new_bit_i;
      second_o = ~cur_bit_i;
    end else begin
      first_o  = ~prev_lvl_i;
      second_o = cur_bit_i ? prev_lvl_i : ~prev_lvl_i;
    end
  end
endmodule

// File: rtl/linecode_modulator.sv
module linecode_modulator
  import lcm_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_valid,
  output logic              load_ready,
  input  logic [DATA_W-1:0] load_data,
  input  logic              half_tick,
  input  logic              code_sel,
  input  logic [CNT_W-1:0]  bit_count,
  output logic              line_out,
  output logic              done
);
  logic rst_meta, rst_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_s    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_s    <= rst_meta;
    end
  end

  logic  busy_q, busy_n, phase_q, phase_n, cur_q, cur_n;
  logic  line_q, line_n, done_q, done_n;
  code_e mode_q, mode_n, mode_eff;
  logic  empty, msb, last, first_lvl, second_lvl;
  logic  start_frame, end_bit, next_bit, finish, mid, begin_bit, load_acc;

  assign load_ready  = empty;
  assign load_acc    = load_valid & empty;
  assign start_frame = ~busy_q & half_tick & ~empty;
  assign end_bit     = busy_q & phase_q & half_tick;
  assign finish      = end_bit & last;
  assign next_bit    = end_bit & ~last & ~empty;
  assign mid         = busy_q & ~phase_q & half_tick;
  assign begin_bit   = start_frame | next_bit;
  assign mode_eff    = start_frame ? code_e'(code_sel) : mode_q;

  lcm_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst_n(rst_s), .load_i(load_acc), .data_i(load_data),
    .shift_i(begin_bit), .flush_i(finish), .empty_o(empty), .msb_o(msb)
  );

  lcm_bitcount #(.CNT_W(CNT_W)) u_count (
    .clk(clk), .rst_n(rst_s), .start_i(start_frame), .len_i(bit_count),
    .dec_i(next_bit), .last_o(last)
  );

  lcm_encoder u_enc (
    .mode_i(mode_eff), .new_bit_i(msb), .cur_bit_i(cur_q),
    .prev_lvl_i(line_q), .first_o(first_lvl), .second_o(second_lvl)
  );

  always_comb begin
    busy_n  = busy_q;
    phase_n = phase_q;
    cur_n   = cur_q;
    line_n  = line_q;
    mode_n  = mode_eff;
    done_n  = finish;
    if (begin_bit) begin
      busy_n  = 1'b1;
      phase_n = 1'b0;
      cur_n   = msb;
      line_n  = first_lvl;
    end else if (mid) begin
      phase_n = 1'b1;
      line_n  = second_lvl;
    end else if (finish) begin
      busy_n  = 1'b0;
      line_n  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      busy_q  <= 1'b0;
      phase_q <= 1'b0;
      cur_q   <= 1'b0;
      line_q  <= 1'b0;
      mode_q  <= CODE_MANCH;
      done_q  <= 1'b0;
    end else begin
      done_q <= done_n;
      if (half_tick) begin
        busy_q  <= busy_n;
        phase_q <= phase_n;
        cur_q   <= cur_n;
        line_q  <= line_n;
        mode_q  <= mode_n;
      end
    end
  end

  assign line_out = line_q;
  assign done     = done_q;

  assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_s)
    done_q |=> !done_q);
  assert_done_idle_low_R6: assert property (@(posedge clk) disable iff (!rst_s)
    done_q |-> !line_q);
  assert_mode_held_R7: assert property (@(posedge clk) disable iff (!rst_s)
    (busy_q && $past(busy_q)) |-> $stable(mode_q));
  assert_manch_mid_edge_R3: assert property (@(posedge clk) disable iff (!rst_s)
    (mid && mode_q == CODE_MANCH) |=> (line_q != $past(line_q)));
  assert_biphase_bound_edge_R4: assert property (@(posedge clk) disable iff (!rst_s)
    (next_bit && mode_q == CODE_BIPHASE) |=> (line_q != $past(line_q)));
endmodule

// File: tb/linecode_modulator_test.sv
module linecode_modulator_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       load_valid = 1'b0;
  logic       load_ready;
  logic [7:0] load_data = '0;
  logic       half_tick = 1'b0;
  logic       code_sel = 1'b0;
  logic [3:0] bit_count = '0;
  logic       line_out, done;

  int tests = 0;
  int fails = 0;
  logic tick_q = 1'b0;
  logic [1:0] exp_q[$];
  string      tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  linecode_modulator #(.DATA_W(8), .CNT_W(4)) uut (
    .clk(clk), .rst_n(rst_n), .load_valid(load_valid), .load_ready(load_ready),
    .load_data(load_data), .half_tick(half_tick), .code_sel(code_sel),
    .bit_count(bit_count), .line_out(line_out), .done(done)
  );

  task automatic check(input bit ok, input string tag, input int got, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  always @(posedge clk) tick_q <= half_tick;

  // monitor: one expected {done,line} item per half_tick
  always @(negedge clk) begin
    if (tick_q) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R5 unexpected tick", {done, line_out}, 0);
      end else begin
        logic [1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check({done, line_out} == e, t, {done, line_out}, e);
      end
    end
  end

  task automatic push(input logic d, input logic l, input string t);
    exp_q.push_back({d, l});
    tag_q.push_back(t);
  endtask

  task automatic do_tick(input bit with_load, input logic [7:0] d);
    @(negedge clk);
    half_tick = 1'b1;
    if (with_load) begin
      load_valid = 1'b1;
      load_data  = d;
    end
    @(negedge clk);
    half_tick  = 1'b0;
    load_valid = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic load_byte(input logic [7:0] d);
    @(negedge clk);
    while (!load_ready) @(negedge clk);
    load_valid = 1'b1;
    load_data  = d;
    @(negedge clk);
    load_valid = 1'b0;
    check(load_ready == 1'b0, "R2 ready low after load", load_ready, 0);
  endtask

  // driver: computes expected half-bit levels and pushes them before ticking
  task automatic run_frame(input logic [7:0] b0, input logic [7:0] b1, input int nbits,
                           input logic mode, input int stall, input bit preload,
                           input bit flip, input bit collide, input logic [7:0] cbyte,
                           input string tag);
    logic prev, bitv, f, s;
    int   total;
    if (preload) load_byte(b0);
    code_sel  = mode;
    bit_count = 4'(nbits - 1);
    prev = 1'b0;
    for (int i = 0; i < nbits; i++) begin
      bitv = (i < 8) ? b0[7-i] : b1[15-i];
      if (i == 8) for (int k = 0; k < stall; k++) push(1'b0, prev, {tag, " R9 hold"});
      f = mode ? ~prev : bitv;
      s = mode ? (bitv ? f : ~f) : ~bitv;
      push(1'b0, f, tag);
      push(1'b0, s, tag);
      prev = s;
    end
    push(1'b1, 1'b0, {tag, " R6 end"});
    total = 2*nbits + 1 + ((nbits > 8) ? stall : 0);
    for (int t = 0; t < total; t++) begin
      if (nbits > 8 && t == 16 + stall) begin
        check(load_ready == 1'b1, "R2 ready after eighth bit", load_ready, 1);
        load_byte(b1);
      end
      if (flip && t == 2) code_sel = ~mode;
      do_tick(collide && (t == total - 1), cbyte);
    end
    code_sel = mode;
    while (exp_q.size() != 0) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog: got 0 expected 1 (run ended)");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(line_out == 1'b0, "R1 line low", line_out, 0);
    check(done == 1'b0, "R1 done low", done, 0);
    check(load_ready == 1'b1, "R1 ready high", load_ready, 1);

    run_frame(8'hA5, 8'h00, 8, 1'b0, 0, 1, 0, 0, 8'h00, "R3 R5 manchester");
    run_frame(8'h4E, 8'h00, 8, 1'b1, 0, 1, 0, 0, 8'h00, "R4 biphase");
    run_frame(8'hC3, 8'h50, 12, 1'b0, 0, 1, 0, 0, 8'h00, "R6 twelve bits");
    run_frame(8'h0F, 8'hB2, 16, 1'b1, 0, 1, 0, 0, 8'h00, "R6 sixteen bits");
    run_frame(8'h96, 8'hE0, 12, 1'b1, 3, 1, 0, 0, 8'h00, "R9 stalled");
    run_frame(8'h6D, 8'h00, 5, 1'b0, 0, 1, 1, 0, 8'h00, "R7 mode change ignored");
    run_frame(8'hA5, 8'h00, 3, 1'b1, 0, 1, 0, 0, 8'h00, "R8 short frame");
    check(load_ready == 1'b1, "R8 leftover bits flushed", load_ready, 1);
    run_frame(8'h3C, 8'h00, 8, 1'b0, 0, 1, 0, 0, 8'h00, "R8 next byte fresh");
    run_frame(8'h81, 8'h00, 8, 1'b1, 0, 1, 0, 1, 8'h5A, "R10 collide frame");
    check(load_ready == 1'b0, "R10 byte kept at frame end", load_ready, 0);
    run_frame(8'h5A, 8'h00, 8, 1'b0, 0, 0, 0, 0, 8'h00, "R10 kept byte sent");
    run_frame(8'h80, 8'h00, 1, 1'b0, 0, 1, 0, 0, 8'h00, "R6 single bit");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule